// File: doc/BRIEF.md
# Miss Tracking Entry with Deferred Target Queue

This block is a single entry of the miss-tracking file in a non-blocking cache. When a miss is first seen, the entry is allocated. It records the block address, the block size, the security and uncacheable attributes, an allocation order number and a ready time, and it stores the first requester as a target. Later requesters to the same block are attached as further targets.

The entry keeps two bounded target queues. The primary queue holds targets that the outstanding request will satisfy. The deferred queue holds targets that must wait for a second request once the first one has been answered. The choice between them depends on whether the entry is already in service, on the pending-modified state, and on two flags that a separate snoop block sets: invalidate-after-response and downgrade-after-response.

The entry supports several operations:
- Issue the request.
- Promote deferred targets once the primary queue has drained.
- Pull deferred targets forward when a writable fill arrives.
- Pop serviced targets.
- Rewrite upgrade commands across a queue.
- Deallocate.

One operation is accepted per cycle. When several strobes are high at once, the priority is: allocate, deallocate, issue, promote, writable fill, add, snoop add, pop, rewrite.

Top module: `miss_entry`

## Requirements
- R1: On allocate, the entry becomes valid and latches address, size, secure, uncacheable, order, ready time and allocate-on-fill. It clears in-service, pending-modified, forward and both post-response flags, and empties both queues. The first target enters the primary queue with source 2 (prefetcher) when its command is 5, and with source 0 (CPU) otherwise.
- R2: Command codes are 0 read, 1 read-exclusive, 2 upgrade, 3 store-conditional upgrade, 4 store-conditional, 5 prefetch, 6 store-conditional-upgrade-fail and 7 store-conditional-fail. Commands 1 to 4 need a writable copy, and commands 2 to 4 count as upgrades. A CPU or allocate target sets the receiving queue's needs-writable and has-upgrade flags accordingly. A snoop target (source 1) sets neither flag.
- R3: A CPU target is sent to the deferred queue only when the entry is in service and at least one of these holds:
  - the deferred queue is non-empty;
  - invalidate-after-response is set;
  - the target needs a writable copy and pending-modified is clear, or downgrade-after-response is set, or forward is set.

  Otherwise the target goes to the primary queue.
- R4: A target deferred while invalidate-after-response is set is rewritten before it is stored: 2 becomes 1, 3 becomes 6 and 4 becomes 7.
- R5: The allocate-on-fill output is the OR of its current value and the flag carried by each accepted CPU target.
- R6: Issue sets in-service, sets pending-modified to the primary needs-writable flag ORed with issue_mod_i, and clears both post-response flags. Issue while already in service raises err_o and changes nothing.
- R7: Issue on a forward entry that expects no response pops its target, invalidates the entry and pulses free_o instead of entering service.
- R8: Promote with an empty primary queue and a non-empty deferred queue swaps the queues and clears the flags of the new deferred queue. It takes the order number from the first promoted target, sets the ready time to the later of now_i and that target's ready time, and pulses promoted_o. With nothing deferred it does nothing. With a non-empty primary queue it raises err_o.
- R9: A writable fill moves the deferred targets, in order, to the end of the primary queue only when the deferred needs-writable flag is set and neither post-response flag is set. After the move, primary needs-writable is set and the deferred flags are cleared.
- R10: Deallocate is accepted only when both queues are empty and the deferred flags are clear. It clears valid, in-service, pending-modified and the primary flags. Otherwise it raises err_o.
- R11: Each queue holds DEPTH targets. An add to a full queue raises err_o for one cycle and leaves the counts unchanged.
- R12: A queue-wide rewrite applies the R4 mapping to every target in that queue only when the queue's has-upgrade flag is set, and then clears that flag. Otherwise the queue is untouched.
- R13: Pop removes the primary head, and the next target becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | TIME_W | Current time |
| alloc_i | input | 1 | Allocate strobe |
| alloc_addr_i | input | ADDR_W | Block address |
| alloc_size_i | input | SIZE_W | Block size |
| alloc_secure_i | input | 1 | Secure attribute |
| alloc_uncache_i | input | 1 | Uncacheable attribute |
| alloc_cmd_i | input | 3 | First target command |
| alloc_order_i | input | ORD_W | Allocation order number |
| alloc_ready_i | input | TIME_W | Ready time |
| alloc_fill_i | input | 1 | Allocate-on-fill |
| add_i | input | 1 | Add CPU target strobe |
| add_cmd_i | input | 3 | CPU target command |
| add_order_i | input | ORD_W | CPU target order |
| add_ready_i | input | TIME_W | CPU target ready time |
| add_fill_i | input | 1 | CPU target allocate-on-fill |
| snp_add_i | input | 1 | Add snoop target strobe |
| snp_cmd_i | input | 3 | Snoop target command |
| snp_order_i | input | ORD_W | Snoop target order |
| issue_i | input | 1 | Mark in service |
| issue_mod_i | input | 1 | Modified response expected |
| promote_i | input | 1 | Promote deferred targets |
| wfill_i | input | 1 | Writable fill arrived |
| pop_i | input | 1 | Pop primary head |
| dealloc_i | input | 1 | Deallocate |
| rw_prim_i | input | 1 | Rewrite upgrades in the primary queue |
| rw_def_i | input | 1 | Rewrite upgrades in the deferred queue |
| set_post_inv_i | input | 1 | Set invalidate-after-response |
| set_post_dgr_i | input | 1 | Set downgrade-after-response |
| set_fwd_i | input | 1 | Mark entry as forward |
| fwd_noresp_i | input | 1 | Forward expects no response |
| valid_o | output | 1 | Entry allocated |
| in_svc_o | output | 1 | Request in service |
| pend_mod_o | output | 1 | Pending modified |
| post_inv_o | output | 1 | Invalidate-after-response |
| post_dgr_o | output | 1 | Downgrade-after-response |
| fwd_o | output | 1 | Forward entry |
| fill_o | output | 1 | Allocate-on-fill |
| blk_addr_o | output | ADDR_W | Block address |
| blk_size_o | output | SIZE_W | Block size |
| secure_o | output | 1 | Secure attribute |
| uncache_o | output | 1 | Uncacheable attribute |
| order_o | output | ORD_W | Order number |
| ready_o | output | TIME_W | Ready time |
| prim_cnt_o | output | CNT_W | Primary queue count |
| def_cnt_o | output | CNT_W | Deferred queue count |
| prim_full_o | output | 1 | Primary queue full |
| prim_empty_o | output | 1 | Primary queue empty |
| def_full_o | output | 1 | Deferred queue full |
| def_empty_o | output | 1 | Deferred queue empty |
| prim_nw_o | output | 1 | Primary needs-writable |
| prim_upg_o | output | 1 | Primary has-upgrade |
| def_nw_o | output | 1 | Deferred needs-writable |
| def_upg_o | output | 1 | Deferred has-upgrade |
| head_cmd_o | output | 3 | Primary head command |
| head_src_o | output | 2 | Primary head source |
| head_order_o | output | ORD_W | Primary head order |
| def_head_cmd_o | output | 3 | Deferred head command |
| err_o | output | 1 | Rejected operation pulse |
| free_o | output | 1 | Forward-without-response freed pulse |
| promoted_o | output | 1 | Promotion performed pulse |

## Verification
The hardest state to reach is a populated deferred queue whose flags either allow or forbid the writable-fill move. Getting there needs a specific sequence through the ports: allocate with a read-only target, issue without a modified response so that pending-modified stays clear, then add a writable target so that it is deferred. Later readers then join the deferred queue only because it is already non-empty. The blocked variant adds a set of invalidate-after-response before the fill. The promote path is reached the same way with downgrade-after-response set, and the primary queue is popped empty before promoting. The moved order is then confirmed by popping the head repeatedly.

// File: rtl/miss_entry.sv
module miss_entry #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 8,
  parameter int ORD_W  = 16,
  parameter int TIME_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [SIZE_W-1:0] alloc_size_i,
  input  logic              alloc_secure_i,
  input  logic              alloc_uncache_i,
  input  logic [2:0]        alloc_cmd_i,
  input  logic [ORD_W-1:0]  alloc_order_i,
  input  logic [TIME_W-1:0] alloc_ready_i,
  input  logic              alloc_fill_i,
  input  logic              add_i,
  input  logic [2:0]        add_cmd_i,
  input  logic [ORD_W-1:0]  add_order_i,
  input  logic [TIME_W-1:0] add_ready_i,
  input  logic              add_fill_i,
  input  logic              snp_add_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ORD_W-1:0]  snp_order_i,
  input  logic              issue_i,
  input  logic              issue_mod_i,
  input  logic              promote_i,
  input  logic              wfill_i,
  input  logic              pop_i,
  input  logic              dealloc_i,
  input  logic              rw_prim_i,
  input  logic              rw_def_i,
  input  logic              set_post_inv_i,
  input  logic              set_post_dgr_i,
  input  logic              set_fwd_i,
  input  logic              fwd_noresp_i,
  output logic              valid_o,
  output logic              in_svc_o,
  output logic              pend_mod_o,
  output logic              post_inv_o,
  output logic              post_dgr_o,
  output logic              fwd_o,
  output logic              fill_o,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic [SIZE_W-1:0] blk_size_o,
  output logic              secure_o,
  output logic              uncache_o,
  output logic [ORD_W-1:0]  order_o,
  output logic [TIME_W-1:0] ready_o,
  output logic [$clog2(DEPTH+1)-1:0] prim_cnt_o,
  output logic [$clog2(DEPTH+1)-1:0] def_cnt_o,
  output logic              prim_full_o,
  output logic              prim_empty_o,
  output logic              def_full_o,
  output logic              def_empty_o,
  output logic              prim_nw_o,
  output logic              prim_upg_o,
  output logic              def_nw_o,
  output logic              def_upg_o,
  output logic [2:0]        head_cmd_o,
  output logic [1:0]        head_src_o,
  output logic [ORD_W-1:0]  head_order_o,
  output logic [2:0]        def_head_cmd_o,
  output logic              err_o,
  output logic              free_o,
  output logic              promoted_o
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [2:0] C_RDX = 3'd1, C_UPG = 3'd2, C_SCU = 3'd3, C_SC = 3'd4,
                         C_PF = 3'd5, C_SCUF = 3'd6, C_SCF = 3'd7;
  localparam logic [1:0] S_CPU = 2'd0, S_SNP = 2'd1, S_PF = 2'd2;

  function automatic logic needs_w(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction
  function automatic logic is_upg(input logic [2:0] c);
    return (c >= 3'd2) && (c <= 3'd4);
  endfunction
  function automatic logic [2:0] rewrite(input logic [2:0] c);
    case (c)
      C_UPG:   return C_RDX;
      C_SCU:   return C_SCUF;
      C_SC:    return C_SCF;
      default: return c;
    endcase
  endfunction

  logic [2:0]        q_cmd [2][DEPTH];
  logic [1:0]        q_src [2][DEPTH];
  logic [ORD_W-1:0]  q_ord [2][DEPTH];
  logic [TIME_W-1:0] q_rdy [2][DEPTH];
  logic [CNT_W-1:0]  q_cnt [2];
  logic              q_nw  [2];
  logic              q_upg [2];
  logic              sel, fwd_nr;

  logic pq, dq, defer, aq, fits, move_ok;
  logic [2:0] acmd;

  assign pq = sel;
  assign dq = ~sel;
  assign defer = in_svc_o && ((q_cnt[dq] != '0) || post_inv_o ||
                 (needs_w(add_cmd_i) && (!pend_mod_o || post_dgr_o || fwd_o)));
  assign aq   = defer ? dq : pq;
  assign acmd = (defer && post_inv_o) ? rewrite(add_cmd_i) : add_cmd_i;
  assign fits = ((CNT_W+1)'(q_cnt[pq]) + (CNT_W+1)'(q_cnt[dq])) <= (CNT_W+1)'(DEPTH);
  assign move_ok = q_nw[dq] && !post_inv_o && !post_dgr_o;

  assign prim_cnt_o     = q_cnt[pq];
  assign def_cnt_o      = q_cnt[dq];
  assign prim_full_o    = q_cnt[pq] == CNT_W'(DEPTH);
  assign def_full_o     = q_cnt[dq] == CNT_W'(DEPTH);
  assign prim_empty_o   = q_cnt[pq] == '0;
  assign def_empty_o    = q_cnt[dq] == '0;
  assign prim_nw_o      = q_nw[pq];
  assign prim_upg_o     = q_upg[pq];
  assign def_nw_o       = q_nw[dq];
  assign def_upg_o      = q_upg[dq];
  assign head_cmd_o     = q_cmd[pq][0];
  assign head_src_o     = q_src[pq][0];
  assign head_order_o   = q_ord[pq][0];
  assign def_head_cmd_o = q_cmd[dq][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < DEPTH; i++) begin
          q_cmd[b][i] <= '0;
          q_src[b][i] <= '0;
          q_ord[b][i] <= '0;
          q_rdy[b][i] <= '0;
        end
        q_cnt[b] <= '0;
        q_nw[b]  <= 1'b0;
        q_upg[b] <= 1'b0;
      end
      sel <= 1'b0;  fwd_nr <= 1'b0;
      valid_o <= 1'b0;  in_svc_o <= 1'b0;  pend_mod_o <= 1'b0;
      post_inv_o <= 1'b0;  post_dgr_o <= 1'b0;  fwd_o <= 1'b0;  fill_o <= 1'b0;
      blk_addr_o <= '0;  blk_size_o <= '0;  secure_o <= 1'b0;  uncache_o <= 1'b0;
      order_o <= '0;  ready_o <= '0;
      err_o <= 1'b0;  free_o <= 1'b0;  promoted_o <= 1'b0;
    end else begin
      err_o <= 1'b0;  free_o <= 1'b0;  promoted_o <= 1'b0;
      if (set_post_inv_i) post_inv_o <= 1'b1;
      if (set_post_dgr_i) post_dgr_o <= 1'b1;
      if (set_fwd_i) begin
        fwd_o  <= 1'b1;
        fwd_nr <= fwd_noresp_i;
      end

      if (alloc_i) begin
        valid_o <= 1'b1;  in_svc_o <= 1'b0;  pend_mod_o <= 1'b0;
        post_inv_o <= 1'b0;  post_dgr_o <= 1'b0;  fwd_o <= 1'b0;  fwd_nr <= 1'b0;
        fill_o <= alloc_fill_i;
        blk_addr_o <= alloc_addr_i;  blk_size_o <= alloc_size_i;
        secure_o <= alloc_secure_i;  uncache_o <= alloc_uncache_i;
        order_o <= alloc_order_i;  ready_o <= alloc_ready_i;
        sel <= 1'b0;
        q_cmd[0][0] <= alloc_cmd_i;
        q_src[0][0] <= (alloc_cmd_i == C_PF) ? S_PF : S_CPU;
        q_ord[0][0] <= alloc_order_i;
        q_rdy[0][0] <= alloc_ready_i;
        q_cnt[0] <= CNT_W'(1);
        q_nw[0]  <= needs_w(alloc_cmd_i);
        q_upg[0] <= is_upg(alloc_cmd_i);
        q_cnt[1] <= '0;  q_nw[1] <= 1'b0;  q_upg[1] <= 1'b0;
      end else if (dealloc_i) begin
        if (q_cnt[pq] == '0 && q_cnt[dq] == '0 && !q_nw[dq] && !q_upg[dq]) begin
          valid_o <= 1'b0;  in_svc_o <= 1'b0;  pend_mod_o <= 1'b0;
          q_nw[pq] <= 1'b0;  q_upg[pq] <= 1'b0;
        end else begin
          err_o <= 1'b1;
        end
      end else if (issue_i) begin
        if (in_svc_o) begin
          err_o <= 1'b1;
        end else if (fwd_o && fwd_nr) begin
          for (int i = 0; i < DEPTH-1; i++) begin
            q_cmd[pq][i] <= q_cmd[pq][i+1];
            q_src[pq][i] <= q_src[pq][i+1];
            q_ord[pq][i] <= q_ord[pq][i+1];
            q_rdy[pq][i] <= q_rdy[pq][i+1];
          end
          if (q_cnt[pq] != '0) q_cnt[pq] <= q_cnt[pq] - 1'b1;
          valid_o <= 1'b0;
          free_o  <= 1'b1;
        end else begin
          in_svc_o   <= 1'b1;
          pend_mod_o <= q_nw[pq] | issue_mod_i;
          post_inv_o <= 1'b0;
          post_dgr_o <= 1'b0;
        end
      end else if (promote_i) begin
        if (q_cnt[pq] != '0) begin
          err_o <= 1'b1;
        end else if (q_cnt[dq] != '0) begin
          sel <= ~sel;
          q_nw[pq]  <= 1'b0;
          q_upg[pq] <= 1'b0;
          order_o <= q_ord[dq][0];
          ready_o <= (now_i > q_rdy[dq][0]) ? now_i : q_rdy[dq][0];
          promoted_o <= 1'b1;
        end
      end else if (wfill_i) begin
        if (move_ok) begin
          if (fits) begin
            for (int i = 0; i < DEPTH; i++) begin
              if (i >= int'(q_cnt[pq]) && i < int'(q_cnt[pq]) + int'(q_cnt[dq])) begin
                q_cmd[pq][i] <= q_cmd[dq][IDX_W'(i - int'(q_cnt[pq]))];
                q_src[pq][i] <= q_src[dq][IDX_W'(i - int'(q_cnt[pq]))];
                q_ord[pq][i] <= q_ord[dq][IDX_W'(i - int'(q_cnt[pq]))];
                q_rdy[pq][i] <= q_rdy[dq][IDX_W'(i - int'(q_cnt[pq]))];
              end
            end
            q_cnt[pq] <= q_cnt[pq] + q_cnt[dq];
            q_cnt[dq] <= '0;
            q_nw[pq]  <= 1'b1;
            q_upg[pq] <= q_upg[pq] | q_upg[dq];
            q_nw[dq]  <= 1'b0;
            q_upg[dq] <= 1'b0;
          end else begin
            err_o <= 1'b1;
          end
        end
      end else if (add_i) begin
        if (q_cnt[aq] == CNT_W'(DEPTH)) begin
          err_o <= 1'b1;
        end else begin
          q_cmd[aq][IDX_W'(q_cnt[aq])] <= acmd;
          q_src[aq][IDX_W'(q_cnt[aq])] <= S_CPU;
          q_ord[aq][IDX_W'(q_cnt[aq])] <= add_order_i;
          q_rdy[aq][IDX_W'(q_cnt[aq])] <= add_ready_i;
          q_cnt[aq] <= q_cnt[aq] + 1'b1;
          if (needs_w(acmd)) q_nw[aq]  <= 1'b1;
          if (is_upg(acmd))  q_upg[aq] <= 1'b1;
          fill_o <= fill_o | add_fill_i;
        end
      end else if (snp_add_i) begin
        if (q_cnt[pq] == CNT_W'(DEPTH)) begin
          err_o <= 1'b1;
        end else begin
          q_cmd[pq][IDX_W'(q_cnt[pq])] <= snp_cmd_i;
          q_src[pq][IDX_W'(q_cnt[pq])] <= S_SNP;
          q_ord[pq][IDX_W'(q_cnt[pq])] <= snp_order_i;
          q_rdy[pq][IDX_W'(q_cnt[pq])] <= now_i;
          q_cnt[pq] <= q_cnt[pq] + 1'b1;
        end
      end else if (pop_i) begin
        if (q_cnt[pq] != '0) begin
          for (int i = 0; i < DEPTH-1; i++) begin
            q_cmd[pq][i] <= q_cmd[pq][i+1];
            q_src[pq][i] <= q_src[pq][i+1];
            q_ord[pq][i] <= q_ord[pq][i+1];
            q_rdy[pq][i] <= q_rdy[pq][i+1];
          end
          q_cnt[pq] <= q_cnt[pq] - 1'b1;
        end
      end else begin
        if (rw_prim_i && q_upg[pq]) begin
          for (int i = 0; i < DEPTH; i++) q_cmd[pq][i] <= rewrite(q_cmd[pq][i]);
          q_upg[pq] <= 1'b0;
        end
        if (rw_def_i && q_upg[dq]) begin
          for (int i = 0; i < DEPTH; i++) q_cmd[dq][i] <= rewrite(q_cmd[dq][i]);
          q_upg[dq] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/miss_entry_chk.sv
module miss_entry_chk #(
  parameter int CNT_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_o,
  input logic             in_svc_o,
  input logic             pend_mod_o,
  input logic             post_inv_o,
  input logic             post_dgr_o,
  input logic [CNT_W-1:0] prim_cnt_o,
  input logic [CNT_W-1:0] def_cnt_o,
  input logic             prim_empty_o,
  input logic             err_o,
  input logic             free_o,
  input logic             promoted_o
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    prim_cnt_o <= CNT_W'(DEPTH) && def_cnt_o <= CNT_W'(DEPTH)); // R11
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (prim_cnt_o == $past(prim_cnt_o) && def_cnt_o == $past(def_cnt_o))); // R11
  AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_svc_o) |-> (!post_inv_o && !post_dgr_o)); // R6
  AST_PEND_NEEDS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    pend_mod_o |-> in_svc_o); // R6
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (prim_empty_o && !in_svc_o)); // R10
  AST_FREE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    free_o |-> (!valid_o && !in_svc_o)); // R7
  AST_PROMOTE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    promoted_o |-> (prim_cnt_o != '0 && def_cnt_o == '0)); // R8
endmodule

bind miss_entry miss_entry_chk #(.CNT_W($clog2(DEPTH+1)), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_o(valid_o), .in_svc_o(in_svc_o),
  .pend_mod_o(pend_mod_o), .post_inv_o(post_inv_o), .post_dgr_o(post_dgr_o),
  .prim_cnt_o(prim_cnt_o), .def_cnt_o(def_cnt_o), .prim_empty_o(prim_empty_o),
  .err_o(err_o), .free_o(free_o), .promoted_o(promoted_o));

// File: tb/tb_miss_entry.sv
`timescale 1ns/1ps
module tb_miss_entry;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] now_i = '0;
  logic alloc_i = 0, alloc_secure_i = 0, alloc_uncache_i = 0, alloc_fill_i = 0;
  logic [31:0] alloc_addr_i = '0, alloc_ready_i = '0, add_ready_i = '0;
  logic [7:0] alloc_size_i = '0;
  logic [2:0] alloc_cmd_i = '0, add_cmd_i = '0, snp_cmd_i = '0;
  logic [15:0] alloc_order_i = '0, add_order_i = '0, snp_order_i = '0;
  logic add_i = 0, add_fill_i = 0, snp_add_i = 0, issue_i = 0, issue_mod_i = 0;
  logic promote_i = 0, wfill_i = 0, pop_i = 0, dealloc_i = 0, rw_prim_i = 0, rw_def_i = 0;
  logic set_post_inv_i = 0, set_post_dgr_i = 0, set_fwd_i = 0, fwd_noresp_i = 0;
  logic valid_o, in_svc_o, pend_mod_o, post_inv_o, post_dgr_o, fwd_o, fill_o;
  logic [31:0] blk_addr_o, ready_o;
  logic [7:0] blk_size_o;
  logic secure_o, uncache_o;
  logic [15:0] order_o, head_order_o;
  logic [CW-1:0] prim_cnt_o, def_cnt_o;
  logic prim_full_o, prim_empty_o, def_full_o, def_empty_o;
  logic prim_nw_o, prim_upg_o, def_nw_o, def_upg_o;
  logic [2:0] head_cmd_o, def_head_cmd_o;
  logic [1:0] head_src_o;
  logic err_o, free_o, promoted_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  miss_entry #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    alloc_i = 0; add_i = 0; snp_add_i = 0; issue_i = 0; promote_i = 0; wfill_i = 0;
    pop_i = 0; dealloc_i = 0; rw_prim_i = 0; rw_def_i = 0;
    set_post_inv_i = 0; set_post_dgr_i = 0; set_fwd_i = 0;
  endtask

  task automatic alloc(input logic [2:0] c, input logic [15:0] o, input logic [31:0] r, input logic f);
    alloc_i = 1; alloc_cmd_i = c; alloc_order_i = o; alloc_ready_i = r; alloc_fill_i = f;
    alloc_addr_i = 32'h0000_1040; alloc_size_i = 8'd64; alloc_secure_i = 1; alloc_uncache_i = 0;
    tick();
  endtask
  task automatic add(input logic [2:0] c, input logic [15:0] o, input logic [31:0] r, input logic f);
    add_i = 1; add_cmd_i = c; add_order_i = o; add_ready_i = r; add_fill_i = f; tick();
  endtask
  task automatic snp(input logic [2:0] c);
    snp_add_i = 1; snp_cmd_i = c; snp_order_i = 16'd77; tick();
  endtask
  task automatic issue(input logic m);
    issue_i = 1; issue_mod_i = m; tick();
  endtask
  task automatic pop();
    pop_i = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 reset valid", valid_o, 0);
    chk("R11 reset prim empty", prim_empty_o, 1);
    chk("R11 reset def empty", def_empty_o, 1);
  endtask

  task automatic t_alloc();
    alloc(3'd5, 16'd5, 32'd100, 1'b0);
    chk("R1 valid", valid_o, 1);
    chk("R1 addr", blk_addr_o, 32'h1040);
    chk("R1 size", blk_size_o, 64);
    chk("R1 secure", secure_o, 1);
    chk("R1 order", order_o, 5);
    chk("R1 ready", ready_o, 100);
    chk("R1 prefetch src", head_src_o, 2);
    chk("R1 count", prim_cnt_o, 1);
    chk("R1 in_svc", in_svc_o, 0);
    alloc(3'd0, 16'd6, 32'd0, 1'b0);
    chk("R1 cpu src", head_src_o, 0);
  endtask

  task automatic t_flags();
    alloc(3'd0, 16'd1, 32'd0, 1'b0);
    snp(3'd1);
    chk("R2 snoop no nw", prim_nw_o, 0);
    chk("R2 snoop count", prim_cnt_o, 2);
    add(3'd1, 16'd2, 32'd0, 1'b0);
    chk("R2 cpu nw", prim_nw_o, 1);
    chk("R2 upg clear", prim_upg_o, 0);
    chk("R5 fill stays", fill_o, 0);
    add(3'd2, 16'd3, 32'd0, 1'b1);
    chk("R2 cpu upg", prim_upg_o, 1);
    chk("R5 fill or", fill_o, 1);
  endtask

  task automatic t_defer();
    alloc(3'd0, 16'd1, 32'd0, 1'b0);
    issue(1'b0);
    chk("R6 in_svc", in_svc_o, 1);
    chk("R6 pend clear", pend_mod_o, 0);
    issue(1'b0);
    chk("R6 double issue err", err_o, 1);
    add(3'd0, 16'd2, 32'd0, 1'b0);
    chk("R3 read to primary", prim_cnt_o, 2);
    add(3'd1, 16'd3, 32'd0, 1'b0);
    chk("R3 writable deferred", def_cnt_o, 1);
    chk("R3 def nw", def_nw_o, 1);
    add(3'd0, 16'd4, 32'd0, 1'b0);
    chk("R3 behind deferred", def_cnt_o, 2);
    chk("R3 primary unchanged", prim_cnt_o, 2);
    alloc(3'd1, 16'd1, 32'd0, 1'b0);
    issue(1'b0);
    chk("R6 pend from nw", pend_mod_o, 1);
    add(3'd2, 16'd2, 32'd0, 1'b0);
    chk("R3 upgrade to primary", prim_cnt_o, 2);
    set_post_dgr_i = 1; tick();
    add(3'd1, 16'd3, 32'd0, 1'b0);
    chk("R3 downgrade defers", def_cnt_o, 1);
  endtask

  task automatic t_postinv();
    alloc(3'd0, 16'd1, 32'd0, 1'b0);
    issue(1'b1);
    chk("R6 pend from input", pend_mod_o, 1);
    set_post_inv_i = 1; tick();
    add(3'd2, 16'd2, 32'd0, 1'b0);
    chk("R4 deferred", def_cnt_o, 1);
    chk("R4 rewritten", def_head_cmd_o, 1);
    chk("R4 no upg", def_upg_o, 0);
    alloc(3'd0, 16'd1, 32'd0, 1'b0);
    set_post_inv_i = 1; set_post_dgr_i = 1; tick();
    issue(1'b0);
    chk("R6 inv cleared", post_inv_o, 0);
    chk("R6 dgr cleared", post_dgr_o, 0);
  endtask

  task automatic t_forward();
    alloc(3'd0, 16'd1, 32'd0, 1'b0);
    set_fwd_i = 1; fwd_noresp_i = 1; tick();
    issue(1'b0);
    chk("R7 free pulse", free_o, 1);
    chk("R7 invalid", valid_o, 0);
    chk("R7 popped", prim_cnt_o, 0);
    chk("R7 not in service", in_svc_o, 0);
    alloc(3'd0, 16'd1, 32'd0, 1'b0);
    set_fwd_i = 1; fwd_noresp_i = 0; tick();
    issue(1'b1);
    add(3'd1, 16'd2, 32'd0, 1'b0);
    chk("R3 forward defers", def_cnt_o, 1);
  endtask

  task automatic t_promote();
    alloc(3'd1, 16'd5, 32'd100, 1'b0);
    issue(1'b0);
    set_post_dgr_i = 1; tick();
    add(3'd1, 16'd9, 32'd300, 1'b0);
    promote_i = 1; tick();
    chk("R8 busy primary err", err_o, 1);
    pop();
    chk("R13 drained", prim_cnt_o, 0);
    now_i = 32'd50;
    promote_i = 1; tick();
    chk("R8 promoted", promoted_o, 1);
    chk("R8 counts", {prim_cnt_o, def_cnt_o}, {CW'(1), CW'(0)});
    chk("R8 order", order_o, 9);
    chk("R8 ready later target", ready_o, 300);
    chk("R8 new def flags clear", def_nw_o, 0);
    chk("R8 prim flag moved", prim_nw_o, 1);
    pop();
    promote_i = 1; tick();
    chk("R8 nothing deferred", {promoted_o, err_o}, 0);
    alloc(3'd0, 16'd5, 32'd10, 1'b0);
    issue(1'b0);
    add(3'd1, 16'd8, 32'd20, 1'b0);
    pop();
    now_i = 32'd500;
    promote_i = 1; tick();
    chk("R8 ready now", ready_o, 500);
    now_i = 0;
  endtask

  task automatic t_wfill();
    alloc(3'd0, 16'd5, 32'd0, 1'b0);
    issue(1'b0);
    add(3'd1, 16'd11, 32'd0, 1'b0);
    add(3'd0, 16'd12, 32'd0, 1'b0);
    add(3'd0, 16'd13, 32'd0, 1'b0);
    chk("R3 three deferred", def_cnt_o, 3);
    wfill_i = 1; tick();
    chk("R9 merged", {prim_cnt_o, def_cnt_o}, {CW'(4), CW'(0)});
    chk("R9 prim nw", prim_nw_o, 1);
    chk("R9 def nw clear", def_nw_o, 0);
    pop();
    chk("R9 order 1", head_order_o, 11);
    pop();
    chk("R13 order 2", head_order_o, 12);
    pop();
    chk("R9 order 3", head_order_o, 13);
    alloc(3'd0, 16'd5, 32'd0, 1'b0);
    issue(1'b0);
    add(3'd1, 16'd11, 32'd0, 1'b0);
    set_post_inv_i = 1; tick();
    wfill_i = 1; tick();
    chk("R9 blocked", {prim_cnt_o, def_cnt_o}, {CW'(1), CW'(1)});
  endtask

  task automatic t_full();
    alloc(3'd0, 16'd1, 32'd0, 1'b0);
    for (int i = 0; i < DEPTH-1; i++) add(3'd0, 16'(i+2), 32'd0, 1'b0);
    chk("R11 full", prim_full_o, 1);
    add(3'd1, 16'd99, 32'd0, 1'b0);
    chk("R11 add err", err_o, 1);
    chk("R11 count kept", prim_cnt_o, DEPTH);
    chk("R11 flag kept", prim_nw_o, 0);
    snp(3'd0);
    chk("R11 snoop err", err_o, 1);
  endtask

  task automatic t_dealloc();
    alloc(3'd1, 16'd1, 32'd0, 1'b0);
    issue(1'b0);
    dealloc_i = 1; tick();
    chk("R10 busy err", err_o, 1);
    chk("R10 still valid", valid_o, 1);
    pop();
    dealloc_i = 1; tick();
    chk("R10 freed", {valid_o, in_svc_o, prim_nw_o, err_o}, 0);
    alloc(3'd0, 16'd1, 32'd0, 1'b0);
    issue(1'b0);
    add(3'd1, 16'd2, 32'd0, 1'b0);
    pop();
    dealloc_i = 1; tick();
    chk("R10 deferred err", err_o, 1);
  endtask

  task automatic t_rewrite();
    alloc(3'd2, 16'd1, 32'd0, 1'b0);
    rw_prim_i = 1; tick();
    chk("R12 rewritten", head_cmd_o, 1);
    chk("R12 upg cleared", prim_upg_o, 0);
    alloc(3'd0, 16'd1, 32'd0, 1'b0);
    snp(3'd2);
    rw_prim_i = 1; tick();
    pop();
    chk("R12 untouched without flag", head_cmd_o, 2);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_alloc();
    t_flags();
    t_defer();
    t_postinv();
    t_forward();
    t_promote();
    t_wfill();
    t_full();
    t_dealloc();
    t_rewrite();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule